// File: doc/BRIEF.md
# Bit-Serial Adder with In-Place Accumulator

This block adds two unsigned words one bit per clock, least significant bit first, using a single full-adder cell and one carry flip-flop. Both operands are copied into shift registers when an addition starts. On every shift cycle the first register moves right and takes the new sum bit in at its top, so after one pass it holds the result in place of the first operand. The second register rotates right and ends each pass holding its original value again.

A start pulse seen while the block is idle loads both operands in parallel and clears the carry. A counter then sequences exactly one shift per operand bit and returns the block to idle. A one-cycle done pulse marks the end of the pass. The result is read from the parallel accumulator output, and the carry out of the top bit stays on a carry flag until the next addition starts.

Top module: `serialAdder`

## Requirements
- R1: After a full pass the accumulator output equals (A + B) modulo 2^W. Each sum bit is the XOR of the two low operand bits and the stored carry, and the carry out is the majority of those three bits.
- R2: After a full pass the carry flag equals bit W of A + B, which is the carry out of the last bit.
- R3: Once start is accepted, busy is high for exactly W clock cycles. Done is high for exactly one cycle, the first cycle in which busy is low again.
- R4: A start accepted while idle loads opA into the accumulator on that edge and clears the carry. A carry left over from an earlier addition therefore never changes the result.
- R5: While busy, the start input and any change on opA or opB are ignored. The busy length and the result are unchanged.
- R6: After k shift cycles (1 <= k <= W), the top k accumulator bits hold the low k sum bits and the low W-k bits hold opA shifted right by k. So the accumulator equals bits W-1..0 of (opA >> k) | (sum << (W-k)).
- R7: A synchronous active-high reset clears the accumulator, the carry flag, busy, done and the counter. This holds even when reset is asserted in the middle of a pass.
- R8: While idle with start low, the accumulator and the carry flag keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins an addition when sampled high while idle |
| opA | input | W | First operand, loaded in parallel at start |
| opB | input | W | Second operand, loaded in parallel at start |
| busy | output | 1 | High while shift cycles are in progress |
| done | output | 1 | One-cycle pulse after the last shift |
| accum | output | W | Contents of the accumulator register |
| carryFlag | output | 1 | Carry out of the most recent bit step |

## Verification
The assertions take for granted that the operand inputs need to be stable only in the cycle where start is accepted. They also assume that reset may arrive at any time, so every clocked property is switched off while reset is high. The stimulus changes inputs only on falling edges. It pulses start only while the block is idle, except in one test that deliberately raises start and changes both operands halfway through a pass to show they are ignored. Reset is applied once at time zero and once in the middle of a pass.

// File: rtl/serAdd_pkg.sv
`timescale 1ns/1ps
package serAdd_pkg;
  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // parallel load of both operands, clear carry
    logic shift;  // one bit-serial step
  } stepCtrl_t;
endpackage

// File: rtl/serAddBitCell.sv
`timescale 1ns/1ps
module serAddBitCell (
  input  logic aBit,
  input  logic bBit,
  input  logic cIn,
  output logic sBit,
  output logic cOut
);
  always_comb begin
    sBit = aBit ^ bBit ^ cIn;
    cOut = (aBit & bBit) | (aBit & cIn) | (bBit & cIn);
  end
endmodule

// File: rtl/serAddCtrl.sv
`timescale 1ns/1ps
module serAddCtrl
  import serAdd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  output stepCtrl_t strobe,
  output logic      busy,
  output logic      done
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          running;
  logic [CW-1:0] stepCnt;
  logic          doneQ;

  always_comb begin
    strobe.load  = !running && start;
    strobe.shift = running;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      stepCnt <= '0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (!running) begin
        if (start) begin
          running <= 1'b1;
          stepCnt <= '0;
        end
      end else if (stepCnt == LAST) begin
        running <= 1'b0;
        stepCnt <= '0;
        doneQ   <= 1'b1;
      end else begin
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end

  assign busy = running;
  assign done = doneQ;

  // R3: done lasts one cycle only
  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    doneQ |=> !doneQ);
  // R3: done appears exactly as busy falls
  a_r3_done_at_fall: assert property (@(posedge clk) disable iff (rst)
    doneQ |-> (!running && $past(running)));
  // R5: a pass cannot end early, whatever start does
  a_r5_no_early_exit: assert property (@(posedge clk) disable iff (rst)
    (running && stepCnt != LAST) |=> (running && stepCnt == $past(stepCnt) + 1'b1));
  // R7: counter sits at zero whenever idle
  a_r7_idle_count_zero: assert property (@(posedge clk) disable iff (rst)
    !running |-> (stepCnt == '0));
endmodule

// File: rtl/serAddDatapath.sv
`timescale 1ns/1ps
module serAddDatapath
  import serAdd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  stepCtrl_t    strobe,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] accum,
  output logic         carryFlag
);
  logic [W-1:0] aReg;
  logic [W-1:0] bReg;
  logic         carryQ;
  logic         sumBit;
  logic         carryNext;

  serAddBitCell cell_i (
    .aBit (aReg[0]),
    .bBit (bReg[0]),
    .cIn  (carryQ),
    .sBit (sumBit),
    .cOut (carryNext)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      aReg   <= '0;
      bReg   <= '0;
      carryQ <= 1'b0;
    end else if (strobe.load) begin
      aReg   <= opA;
      bReg   <= opB;
      carryQ <= 1'b0;
    end else if (strobe.shift) begin
      aReg   <= {sumBit, aReg[W-1:1]};
      bReg   <= {bReg[0], bReg[W-1:1]};
      carryQ <= carryNext;
    end
  end

  assign accum     = aReg;
  assign carryFlag = carryQ;

  // R4: a load takes opA and starts with no carry
  a_r4_load_clears_carry: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> (carryQ == 1'b0 && aReg == $past(opA)));
  // R6: untouched operand bits move down one place per step
  a_r6_low_bits_move: assert property (@(posedge clk) disable iff (rst)
    strobe.shift |=> (aReg[W-2:0] == $past(aReg[W-1:1])));
  // R8: no strobe, no change
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !(strobe.load || strobe.shift) |=> ($stable(aReg) && $stable(carryQ)));
  // R5: never load and shift together
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.load, strobe.shift}));
endmodule

// File: rtl/serialAdder.sv
`timescale 1ns/1ps
module serialAdder #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] accum,
  output logic         carryFlag
);
  serAdd_pkg::stepCtrl_t strobe;

  serAddCtrl #(.W(W)) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  serAddDatapath #(.W(W)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .opA       (opA),
    .opB       (opB),
    .accum     (accum),
    .carryFlag (carryFlag)
  );
endmodule

// File: tb/serialAdder_tb_top.sv
`timescale 1ns/1ps
module serialAdder_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         busy, done, carryFlag;
  logic [W-1:0] accum;

  int testCount = 0;
  int failCount = 0;

  always #2.5 clk = ~clk;

  serialAdder #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .opA(opA), .opB(opB),
    .busy(busy), .done(done), .accum(accum), .carryFlag(carryFlag)
  );

  // {a, b} pairs
  localparam logic [15:0] VEC [8] = '{
    16'h0000, 16'h0101, 16'hFF01, 16'h55AA,
    16'h8080, 16'hFFFF, 16'h3C0F, 16'h0000
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] partial(input logic [W-1:0] a,
                                           input logic [W-1:0] s, input int k);
    logic [2*W-1:0] t;
    t = ({{W{1'b0}}, a} >> k) | ({{W{1'b0}}, s} << (W - k));
    return t[W-1:0];
  endfunction

  // full addition; optionally disturbs inputs mid-pass (R5)
  task automatic runAdd(input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit disturb);
    logic [W:0] full;
    full = {1'b0, a} + {1'b0, b};
    @(negedge clk);
    opA = a; opB = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(accum == a, "R4", "load value", 16'(accum), 16'(a));
    chk(busy == 1'b1, "R3", "busy after start", 16'(busy), 16'd1);
    chk(carryFlag == 1'b0, "R4", "carry cleared", 16'(carryFlag), 16'd0);
    for (int k = 1; k <= W; k++) begin
      @(negedge clk);
      if (k < W) begin
        chk(accum == partial(a, full[W-1:0], k), "R6", "partial accum",
            16'(accum), 16'(partial(a, full[W-1:0], k)));
        chk(busy == 1'b1 && done == 1'b0, "R3", "busy mid pass",
            16'({busy, done}), 16'b10);
      end
      if (disturb && k == 3) begin
        start = 1'b1; opA = ~a; opB = 8'h5A;
      end
      if (disturb && k == 5) start = 1'b0;
    end
    chk(accum == full[W-1:0], disturb ? "R5" : "R1", "sum",
        16'(accum), 16'(full[W-1:0]));
    chk(carryFlag == full[W], "R2", "carry out", 16'(carryFlag), 16'(full[W]));
    chk(busy == 1'b0 && done == 1'b1, "R3", "end of pass",
        16'({busy, done}), 16'b01);
    @(negedge clk);
    chk(done == 1'b0, "R3", "done single", 16'(done), 16'd0);
    chk(accum == full[W-1:0] && carryFlag == full[W], "R8", "idle hold",
        16'({carryFlag, accum}), 16'(full));
  endtask

  initial begin
    #1000000;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(accum == 0 && carryFlag == 0 && busy == 0 && done == 0, "R7",
        "reset state", 16'({done, busy, carryFlag, accum}), 16'd0);
    rst = 1'b0;

    for (int i = 0; i < 8; i++) runAdd(VEC[i][15:8], VEC[i][7:0], 1'b0);

    // R4: carry 1 left by FF+FF must not leak into 00+01
    runAdd(8'hFF, 8'hFF, 1'b0);
    runAdd(8'h00, 8'h01, 1'b0);

    // R5: start and operands disturbed mid-pass
    runAdd(8'hC3, 8'h7E, 1'b1);

    // R8: long idle keeps result
    repeat (5) @(negedge clk);
    chk(accum == 8'h41 && carryFlag == 1'b1, "R8", "long idle",
        16'({carryFlag, accum}), 16'h141);

    // R7: reset in mid pass
    @(negedge clk);
    opA = 8'hF0; opB = 8'h0F; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(accum == 0 && carryFlag == 0 && busy == 0 && done == 0, "R7",
        "mid-pass reset", 16'({done, busy, carryFlag, accum}), 16'd0);
    repeat (W + 2) @(negedge clk);
    chk(done == 0 && busy == 0 && accum == 0, "R7", "stays idle after reset",
        16'({done, busy, accum}), 16'd0);

    runAdd(8'h12, 8'h34, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule